// File: doc/BRIEF.md
# Serial FPGA configuration sequencer

This block loads a configuration bit stream into a target FPGA through its slave-serial port. It owns three pins toward the target: an active-low program strobe, a serial clock and a serial data line. It watches two status lines coming back from the target: an initialisation-ready line and a configuration-complete line. Both are passed through synchronisers before use.

A start pulse begins a load. The sequencer holds the program strobe low until the target pulls its initialisation line low. It then releases the strobe and waits for the initialisation line to rise again. Next it shifts in bytes from an upstream source, most significant bit first, and stops after the byte flagged as last. Finally it waits for the completion line. Every wait is sampled once per poll interval and gives up after a bounded number of failed samples. The three possible timeouts each report their own result code. A busy flag covers the whole load. The result code then holds until the next start.

Each serial bit uses four equal phases:
- clock low with data high;
- clock low with data set to the bit;
- clock high with the bit held;
- clock high with data returned to one.

The serial clock therefore only ever falls while data is high.

Top module: `fpga_serial_loader`

## Requirements
- R1: After reset, and whenever `busy_o` is low, `prog_n_o`, `cclk_o` and `din_o` are all 1, and `result_o` reads 0 after reset.
- R2: In the cycle after a start is accepted, `prog_n_o` is 0 while `cclk_o` and `din_o` stay 1. `prog_n_o` returns to 1 only after a poll sample sees `tgt_init_i` low.
- R3: After `prog_n_o` is released, no rising edge appears on `cclk_o` until a poll sample sees `tgt_init_i` high.
- R4: Every serial bit keeps `cclk_o` low for exactly 2*PHASE_CYCLES cycles. `din_o` is 1 in the first cycle of every low period and holds the bit value when `cclk_o` rises. While the clock is high, `din_o` only ever changes to 1.
- R5: A byte is taken when `byte_valid_i` and `byte_ready_o` are both 1. Its bits go out most significant first, bytes in the order taken. The bit stream ends after the byte taken with `byte_last_i` = 1. `byte_ready_o` is 1 only while busy, with the program strobe released and the clock high.
- R6: When the current byte is exhausted and no byte is offered, `cclk_o` and `din_o` stay 1 and `byte_ready_o` stays 1 until a byte arrives.
- R7: After the last bit, a poll sample that sees `tgt_done_i` high ends the load with result code 1 (success).
- R8: A wait samples its condition once every POLL_CYCLES cycles, the first sample POLL_CYCLES cycles after the wait begins. It fails on the MAX_POLLS-th consecutive failed sample. A condition first seen true at the MAX_POLLS-th sample counts as met.
- R9: The three timeouts report distinct result codes: 2 when the initialisation line never goes low, 3 when it never returns high, and 4 when completion never rises. After any of them, all three pins return to 1. `result_o` never exceeds 4.
- R10: `busy_o` rises on the cycle after an accepted start and falls in the same cycle the result is written. While busy, `result_o` is 0. While not busy, `result_o` holds its value until the next start.
- R11: A start pulse while `busy_o` is 1 is ignored; the running load continues and its program strobe stays released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start a load (ignored while busy) |
| byte_data_i | input | BYTE_W | Next configuration byte |
| byte_valid_i | input | 1 | Upstream byte is valid |
| byte_last_i | input | 1 | Offered byte is the final one |
| byte_ready_o | output | 1 | Sequencer takes the byte this cycle if valid |
| tgt_init_i | input | 1 | Target initialisation-ready line (asynchronous) |
| tgt_done_i | input | 1 | Target configuration-complete line (asynchronous) |
| prog_n_o | output | 1 | Active-low program strobe to target |
| cclk_o | output | 1 | Serial configuration clock |
| din_o | output | 1 | Serial configuration data |
| busy_o | output | 1 | Load in progress |
| result_o | output | 3 | 0 none, 1 success, 2/3/4 timeout codes |

## Verification
The timeout decision and the condition being met can fall on the same poll sample. This is the case where an off-by-one turns a late but valid target response into a spurious error. The bench provokes it by having the modelled target drop its initialisation line between the third and the fourth of four samples. It judges the run by a success code together with a program-strobe low time of exactly four poll intervals plus one cycle. A second overlap, a start pulse arriving mid-stream, is judged by the strobe staying released and by the captured bit stream matching the offered bytes.

// File: rtl/fsl_pkg.sv
package fsl_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE   = 3'd0,
    SQ_PROG   = 3'd1,
    SQ_WAKE   = 3'd2,
    SQ_STREAM = 3'd3,
    SQ_SETTLE = 3'd4
  } sq_state_t;

  typedef enum logic [1:0] {
    PH_LEAD,
    PH_SETUP,
    PH_HIGH,
    PH_TRAIL
  } bit_phase_t;

  localparam logic [2:0] RES_NONE         = 3'd0;
  localparam logic [2:0] RES_OK           = 3'd1;
  localparam logic [2:0] RES_NO_INIT_LOW  = 3'd2;
  localparam logic [2:0] RES_NO_INIT_HIGH = 3'd3;
  localparam logic [2:0] RES_NO_DONE      = 3'd4;

endpackage

// File: rtl/fsl_sync.sv
module fsl_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] stg;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[0] <= RST_VAL;
          else     stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[g] <= RST_VAL;
          else     stg[g] <= stg[g-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];

endmodule

// File: rtl/fsl_poll_timer.sv
module fsl_poll_timer #(
  parameter int PERIOD = 50000,
  parameter int LIMIT  = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick_o,
  output logic expired_o
);

  localparam int CW = $clog2(PERIOD + 1);
  localparam int NW = $clog2(LIMIT + 1);

  logic [CW-1:0] cyc;
  logic [NW-1:0] polls;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cyc    <= '0;
      polls  <= '0;
      tick_o <= 1'b0;
    end else if (cyc == CW'(PERIOD - 1)) begin
      cyc    <= '0;
      tick_o <= 1'b1;
      if (polls != NW'(LIMIT)) polls <= polls + 1'b1;
    end else begin
      cyc    <= cyc + 1'b1;
      tick_o <= 1'b0;
    end
  end

  // true in the tick cycle of the LIMIT-th sample
  assign expired_o = (polls == NW'(LIMIT));

endmodule

// File: rtl/fsl_bit_phaser.sv
module fsl_bit_phaser
  import fsl_pkg::*;
#(
  parameter int PHASE_CYCLES = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic go_i,
  input  logic bit_i,
  output logic cclk_o,
  output logic din_o,
  output logic active_o,
  output logic done_o
);

  localparam int TW = $clog2(PHASE_CYCLES + 1);

  bit_phase_t    ph;
  logic [TW-1:0] tc;
  logic          bq;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph       <= PH_LEAD;
      tc       <= '0;
      bq       <= 1'b1;
      active_o <= 1'b0;
      cclk_o   <= 1'b1;
      din_o    <= 1'b1;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!active_o) begin
        if (go_i) begin
          active_o <= 1'b1;
          ph       <= PH_LEAD;
          tc       <= '0;
          bq       <= bit_i;
          cclk_o   <= 1'b0;
          din_o    <= 1'b1;
        end
      end else if (tc != TW'(PHASE_CYCLES - 1)) begin
        tc <= tc + 1'b1;
      end else begin
        tc <= '0;
        case (ph)
          PH_LEAD: begin
            ph    <= PH_SETUP;
            din_o <= bq;
          end
          PH_SETUP: begin
            ph     <= PH_HIGH;
            cclk_o <= 1'b1;
          end
          PH_HIGH: begin
            ph    <= PH_TRAIL;
            din_o <= 1'b1;
          end
          default: begin
            ph       <= PH_LEAD;
            active_o <= 1'b0;
            done_o   <= 1'b1;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/fsl_byte_shifter.sv
module fsl_byte_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  input  logic         last_i,
  input  logic         shift_i,
  output logic         bit_o,
  output logic         empty_o,
  output logic         final_o
);

  localparam int CNW = $clog2(W + 1);

  logic [W-1:0]   sr;
  logic [CNW-1:0] cnt;
  logic           lastq;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sr    <= '0;
      cnt   <= '0;
      lastq <= 1'b0;
    end else if (load_i) begin
      sr    <= data_i;
      cnt   <= CNW'(W);
      lastq <= last_i;
    end else if (shift_i) begin
      sr  <= sr << 1;
      cnt <= cnt - 1'b1;
    end
  end

  assign bit_o   = sr[W-1];
  assign empty_o = (cnt == '0);
  assign final_o = lastq && (cnt == CNW'(1));

endmodule

// File: rtl/fpga_serial_loader.sv
module fpga_serial_loader
  import fsl_pkg::*;
#(
  parameter int POLL_CYCLES  = 50000,
  parameter int MAX_POLLS    = 4,
  parameter int PHASE_CYCLES = 1,
  parameter int SYNC_STAGES  = 2,
  parameter int BYTE_W       = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [BYTE_W-1:0] byte_data_i,
  input  logic              byte_valid_i,
  input  logic              byte_last_i,
  output logic              byte_ready_o,
  input  logic              tgt_init_i,
  input  logic              tgt_done_i,
  output logic              prog_n_o,
  output logic              cclk_o,
  output logic              din_o,
  output logic              busy_o,
  output logic [2:0]        result_o
);

  sq_state_t  state, nxt;
  logic       init_s, done_s;
  logic       tick, expired, tmr_clr, in_wait;
  logic       ph_go, ph_active, ph_done, sh_bit, sh_empty, sh_final;
  logic       sh_load, sh_clr;
  logic       fin;
  logic [2:0] fin_code;

  fsl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_init (
    .clk(clk), .rst(rst), .d(tgt_init_i), .q(init_s)
  );

  fsl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_done (
    .clk(clk), .rst(rst), .d(tgt_done_i), .q(done_s)
  );

  fsl_poll_timer #(.PERIOD(POLL_CYCLES), .LIMIT(MAX_POLLS)) u_timer (
    .clk(clk), .rst(rst), .clr(tmr_clr), .tick_o(tick), .expired_o(expired)
  );

  fsl_bit_phaser #(.PHASE_CYCLES(PHASE_CYCLES)) u_phaser (
    .clk(clk), .rst(rst), .go_i(ph_go), .bit_i(sh_bit),
    .cclk_o(cclk_o), .din_o(din_o), .active_o(ph_active), .done_o(ph_done)
  );

  fsl_byte_shifter #(.W(BYTE_W)) u_shifter (
    .clk(clk), .rst(rst), .clr(sh_clr), .load_i(sh_load),
    .data_i(byte_data_i), .last_i(byte_last_i), .shift_i(ph_done),
    .bit_o(sh_bit), .empty_o(sh_empty), .final_o(sh_final)
  );

  always_comb begin
    nxt      = state;
    fin      = 1'b0;
    fin_code = RES_NONE;
    case (state)
      SQ_IDLE: begin
        if (start_i) nxt = SQ_PROG;
      end
      SQ_PROG: begin
        if (tick) begin
          if (!init_s) begin
            nxt = SQ_WAKE;
          end else if (expired) begin
            nxt      = SQ_IDLE;
            fin      = 1'b1;
            fin_code = RES_NO_INIT_LOW;
          end
        end
      end
      SQ_WAKE: begin
        if (tick) begin
          if (init_s) begin
            nxt = SQ_STREAM;
          end else if (expired) begin
            nxt      = SQ_IDLE;
            fin      = 1'b1;
            fin_code = RES_NO_INIT_HIGH;
          end
        end
      end
      SQ_STREAM: begin
        if (ph_done && sh_final) nxt = SQ_SETTLE;
      end
      SQ_SETTLE: begin
        if (tick) begin
          if (done_s) begin
            nxt      = SQ_IDLE;
            fin      = 1'b1;
            fin_code = RES_OK;
          end else if (expired) begin
            nxt      = SQ_IDLE;
            fin      = 1'b1;
            fin_code = RES_NO_DONE;
          end
        end
      end
      default: nxt = SQ_IDLE;
    endcase
  end

  assign in_wait = (state == SQ_PROG) || (state == SQ_WAKE) || (state == SQ_SETTLE);
  // restart the poll interval on every entry into a wait
  assign tmr_clr = !in_wait || (nxt != state);

  // a new bit or byte is only handled once the previous bit has fully retired
  assign byte_ready_o = (state == SQ_STREAM) && sh_empty && !ph_active && !ph_done;
  assign sh_load      = byte_ready_o && byte_valid_i;
  assign ph_go        = (state == SQ_STREAM) && !sh_empty && !ph_active && !ph_done;
  assign sh_clr       = (state == SQ_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SQ_IDLE;
      prog_n_o <= 1'b1;
      busy_o   <= 1'b0;
      result_o <= RES_NONE;
    end else begin
      state    <= nxt;
      prog_n_o <= (nxt != SQ_PROG);
      if (state == SQ_IDLE && start_i) begin
        busy_o   <= 1'b1;
        result_o <= RES_NONE;
      end else if (fin) begin
        busy_o   <= 1'b0;
        result_o <= fin_code;
      end
    end
  end

endmodule

// File: rtl/fsl_checker.sv
module fsl_checker (
  input logic       clk,
  input logic       rst,
  input logic       start_i,
  input logic       byte_ready_o,
  input logic       prog_n_o,
  input logic       cclk_o,
  input logic       din_o,
  input logic       busy_o,
  input logic [2:0] result_o
);

  assert_idle_pins_R1: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (prog_n_o && cclk_o && din_o));

  assert_prog_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !prog_n_o |-> (cclk_o && din_o));

  assert_fall_data_high_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(cclk_o) |-> din_o);

  assert_high_only_to_one_R4: assert property (@(posedge clk) disable iff (rst)
    (cclk_o && $past(cclk_o) && !$stable(din_o)) |-> din_o);

  assert_ready_context_R5: assert property (@(posedge clk) disable iff (rst)
    byte_ready_o |-> (busy_o && prog_n_o && cclk_o));

  assert_code_range_R9: assert property (@(posedge clk) disable iff (rst)
    result_o <= 3'd4);

  assert_start_clears_R10: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && start_i) |=> (busy_o && result_o == 3'd0));

  assert_busy_no_result_R10: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> (result_o == 3'd0));

  assert_result_holds_R10: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !start_i) |=> $stable(result_o));

  assert_restart_ignored_R11: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i && prog_n_o) |=> prog_n_o);

endmodule

bind fpga_serial_loader fsl_checker u_fsl_checker (
  .clk(clk),
  .rst(rst),
  .start_i(start_i),
  .byte_ready_o(byte_ready_o),
  .prog_n_o(prog_n_o),
  .cclk_o(cclk_o),
  .din_o(din_o),
  .busy_o(busy_o),
  .result_o(result_o)
);

// File: tb/fpga_serial_loader_tb_top.sv
module fpga_serial_loader_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int TB_POLL    = 20;
  localparam int TB_MAXP    = 4;
  localparam int TB_PHASE   = 2;

  logic       clk, rst, start;
  logic [7:0] bdata;
  logic       bvalid, blast, bready;
  logic       tinit, tdone;
  logic       prog_n, cclk, din, busy;
  logic [2:0] result;

  int n_chk = 0;
  int n_fail = 0;

  // target model configuration and monitor state
  logic mdl_clear = 1'b0;
  int   cfg_lo_en, cfg_hi_en, cfg_done_en, cfg_lo_dly, cfg_hi_dly, cfg_done_dly, cfg_bits;
  int   cap_n, prog_low, lo_cnt, hi_cnt, dn_cnt, viol4, viol3, lowlen;
  logic pcclk;
  logic cap_bits [0:255];
  logic [7:0] stream [0:7];
  int   stall_bad, poke_bad;

  fpga_serial_loader #(
    .POLL_CYCLES(TB_POLL), .MAX_POLLS(TB_MAXP), .PHASE_CYCLES(TB_PHASE),
    .SYNC_STAGES(2), .BYTE_W(8)
  ) dut_i (
    .clk(clk), .rst(rst), .start_i(start),
    .byte_data_i(bdata), .byte_valid_i(bvalid), .byte_last_i(blast), .byte_ready_o(bready),
    .tgt_init_i(tinit), .tgt_done_i(tdone),
    .prog_n_o(prog_n), .cclk_o(cclk), .din_o(din),
    .busy_o(busy), .result_o(result)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  // target model plus pin monitor, evaluated away from the active edge
  initial begin
    tinit = 1'b1; tdone = 1'b0; pcclk = 1'b1;
    cap_n = 0; prog_low = 0; lo_cnt = 0; hi_cnt = 0; dn_cnt = 0;
    viol4 = 0; viol3 = 0; lowlen = 0;
    forever begin
      @(negedge clk);
      if (mdl_clear) begin
        tinit = 1'b1; tdone = 1'b0; pcclk = 1'b1;
        cap_n = 0; prog_low = 0; lo_cnt = 0; hi_cnt = 0; dn_cnt = 0;
        viol4 = 0; viol3 = 0; lowlen = 0;
      end else begin
        if (!prog_n) prog_low++;
        if (pcclk && !cclk && !din) viol4++;
        if (!cclk) lowlen++;
        if (!pcclk && cclk) begin
          if (lowlen != 2*TB_PHASE) viol4++;
          if (!tinit) viol3++;
          if (cap_n < 256) cap_bits[cap_n] = din;
          cap_n++;
          lowlen = 0;
        end
        pcclk = cclk;
        if (!prog_n) begin
          tdone = 1'b0; hi_cnt = 0; dn_cnt = 0;
          if (tinit && cfg_lo_en != 0) begin
            lo_cnt++;
            if (lo_cnt >= cfg_lo_dly) tinit = 1'b0;
          end
        end else begin
          lo_cnt = 0;
          if (!tinit && cfg_hi_en != 0 && busy) begin
            hi_cnt++;
            if (hi_cnt >= cfg_hi_dly) tinit = 1'b1;
          end
          if (tinit && cfg_done_en != 0 && cfg_bits > 0 && cap_n >= cfg_bits && !tdone) begin
            dn_cnt++;
            if (dn_cnt >= cfg_done_dly) tdone = 1'b1;
          end
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run hung actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_model();
    mdl_clear = 1'b1;
    repeat (2) @(negedge clk);
    mdl_clear = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 20000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic feed(input int nb, input int gap_at);
    for (int i = 0; i < nb; i++) begin
      if (i == gap_at) begin
        bvalid = 1'b0;
        for (int g = 0; g < 2000 && !bready; g++) @(negedge clk);
        for (int k = 0; k < 6; k++) begin
          @(negedge clk);
          if (!(cclk && din && bready)) stall_bad++;
        end
      end
      bdata = stream[i]; blast = (i == nb - 1); bvalid = 1'b1;
      for (int g = 0; g < 5000 && !bready; g++) @(negedge clk);
      @(negedge clk);
    end
    bvalid = 1'b0; blast = 1'b0;
  endtask

  task automatic poke_start();
    wait (cap_n >= 3);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int k = 0; k < 4; k++) begin
      if (!prog_n || !busy) poke_bad++;
      @(negedge clk);
    end
  endtask

  task automatic compare_bits(input int nb);
    int bad = 0;
    for (int i = 0; i < nb; i++)
      for (int b = 7; b >= 0; b--)
        if (cap_bits[i*8 + (7 - b)] !== stream[i][b]) bad++;
    chk(bad == 0, "R5 bit order msb first", bad, 0);
  endtask

  task automatic t_reset_state();
    chk(prog_n && cclk && din, "R1 pins high after reset", {prog_n, cclk, din}, 7);
    chk(busy == 1'b0, "R1 busy low after reset", busy, 0);
    chk(result == 3'd0, "R1 result zero after reset", result, 0);
    chk(bready == 1'b0, "R5 no ready when idle", bready, 0);
  endtask

  task automatic t_load(input int nb, input int gap_at, input int lo_dly,
                        input int exp_prog_low, input bit poke, input int prev_res);
    int n;
    cfg_lo_en = 1; cfg_hi_en = 1; cfg_done_en = 1;
    cfg_lo_dly = lo_dly; cfg_hi_dly = 6; cfg_done_dly = 3; cfg_bits = nb * 8;
    stall_bad = 0; poke_bad = 0;
    clear_model();
    chk(result == 3'(prev_res), "R10 result held before start", result, prev_res);
    pulse_start();
    chk(!prog_n && cclk && din, "R2 strobe low, clock and data high", {prog_n, cclk, din}, 3);
    chk(busy && result == 3'd0, "R10 busy set, result cleared", {busy, result}, 8);
    fork
      feed(nb, gap_at);
      wait_idle(n);
      if (poke) poke_start();
    join
    chk(result == 3'd1, "R7 success code", result, 1);
    chk(cap_n == nb * 8, "R5 bit count", cap_n, nb * 8);
    compare_bits(nb);
    chk(viol4 == 0, "R4 per-bit pin timing", viol4, 0);
    chk(viol3 == 0, "R3 no clock before init high", viol3, 0);
    chk(prog_low == exp_prog_low, "R8 R2 strobe low length", prog_low, exp_prog_low);
    if (gap_at >= 0) chk(stall_bad == 0, "R6 starved pins high", stall_bad, 0);
    if (poke) chk(poke_bad == 0, "R11 start while busy ignored", poke_bad, 0);
    chk(prog_n && cclk && din, "R1 pins high after load", {prog_n, cclk, din}, 7);
  endtask

  task automatic t_error(input int lo_en, input int hi_en, input int done_en,
                         input int exp_code, input int nb);
    int n;
    cfg_lo_en = lo_en; cfg_hi_en = hi_en; cfg_done_en = done_en;
    cfg_lo_dly = 5; cfg_hi_dly = 6; cfg_done_dly = 3; cfg_bits = nb * 8;
    stall_bad = 0;
    clear_model();
    pulse_start();
    chk(busy && result == 3'd0, "R10 result cleared by start", {busy, result}, 8);
    fork
      if (nb > 0) feed(nb, -1);
      wait_idle(n);
    join
    chk(result == 3'(exp_code), "R9 distinct timeout code", result, exp_code);
    chk(prog_n && cclk && din, "R9 pins released after timeout", {prog_n, cclk, din}, 7);
    if (exp_code == 2)
      chk(n >= TB_MAXP*TB_POLL && n <= TB_MAXP*TB_POLL + 2, "R8 timeout window",
          n, TB_MAXP*TB_POLL + 1);
    if (nb > 0) chk(cap_n == nb * 8, "R5 bits sent before done wait", cap_n, nb * 8);
    repeat (40) @(negedge clk);
    chk(result == 3'(exp_code), "R10 result holds while idle", result, exp_code);
  endtask

  initial begin
    rst = 1'b1; start = 1'b0; bvalid = 1'b0; blast = 1'b0; bdata = 8'h00;
    cfg_lo_en = 0; cfg_hi_en = 0; cfg_done_en = 0;
    cfg_lo_dly = 0; cfg_hi_dly = 0; cfg_done_dly = 0; cfg_bits = 0;
    stall_bad = 0; poke_bad = 0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_reset_state();

    // three bytes, upstream starves before byte 1, start poked mid-stream
    stream[0] = 8'hA5; stream[1] = 8'h0F; stream[2] = 8'h81;
    t_load(3, 1, 5, TB_POLL + 1, 1'b1, 0);

    // init never goes low
    t_error(0, 0, 0, 2, 0);

    // init falls between sample 3 and sample 4: met on the final sample
    stream[0] = 8'h6E;
    t_load(1, -1, 70, TB_MAXP*TB_POLL + 1, 1'b0, 2);

    // init never returns high
    t_error(1, 0, 0, 3, 0);

    // completion never rises
    stream[0] = 8'hC3;
    t_error(1, 1, 0, 4, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule